// File: doc/BRIEF.md
# Request-to-Packet Network Wrapper

This block sits between a split-transaction master and a packet-switched on-chip network link. It takes a read or write request from the master and turns it into a short packet of 36-bit flits. Each flit carries a 32-bit word and four tag bits. Two of the tag bits delimit the packet: one marks the opening word and one marks the closing word. The first word is a header. It names the destination terminal, which is copied from the top byte of the request address. It also names this wrapper's own terminal number, the transaction identifier and an opcode. The address word follows. For a write, the data word comes last.

Words leave only while the wrapper holds a credit for the downstream buffer. It starts with as many credits as that buffer has slots, spends one per word and gets one back per credit pulse from the link. Response packets arrive on a separate incoming link. Each completed response packet is reduced to a single response beat that carries the identifier found in its header. Several requests can therefore be outstanding, and their responses are handed to the master in whatever order the network delivers them.

Top module: `req_pkt_wrapper`

## Requirements
- R1: During and directly after reset the wrapper accepts requests (reqReady high), sends nothing (linkValid low) and presents no response (rspValid low).
- R2: The header word holds the destination in bits [31:24], taken from request address bits [31:24]. It holds the SRC_TERM parameter in [23:16], the request identifier in [15:8] and the opcode in [7:0], where 0x01 means read and 0x02 means write.
- R3: A write is sent as three words (header, full 32-bit address, write data). A read is sent as two words (header, address). While credits last, the words go out on consecutive cycles starting the cycle after the request is accepted.
- R4: Flit bit 32 is set only on the first word of a packet. Flit bit 33 is set only on the last word. Bits 35:34 are zero.
- R5: The credit count starts at CREDITS (default 4) and falls by one for each word sent. When it is zero, linkValid stays low and the pending word waits.
- R6: Each cycle with linkCredit high adds one credit. A credit returned in the same cycle that a word is sent leaves the count unchanged, so a link that returns every credit keeps words flowing every cycle.
- R7: reqReady is low from the cycle after a request is accepted until the last word of its packet has been sent. A request held during that time is taken only once the wrapper is idle again.
- R8: An incoming word with bit 33 set ends a response packet. In the next cycle rspValid is high for exactly one cycle, with rspId set to header bits [15:8] and rspData set to the closing word. rspWrite is high when the header opcode is 0x02.
- R9: An incoming one-word response packet (bits 32 and 33 both set) produces a beat that takes its identifier and opcode from that word, with rspData equal to zero.
- R10: Response beats come out in the order their packets arrive, whatever their identifiers, and a payload of any length produces one beat carrying its last word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Master presents a request |
| reqReady | output | 1 | Wrapper accepts the request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 32 | Request address; top byte selects the destination |
| reqWdata | input | 32 | Write data |
| reqId | input | 8 | Transaction identifier |
| linkValid | output | 1 | Outgoing flit is valid and consumed this cycle |
| linkFlit | output | 36 | Outgoing flit: tags [35:32], word [31:0] |
| linkCredit | input | 1 | One credit returned by the downstream buffer |
| rspLinkValid | input | 1 | Incoming response flit is valid |
| rspLinkFlit | input | 36 | Incoming response flit |
| rspValid | output | 1 | Response beat valid (one cycle) |
| rspWrite | output | 1 | Response belongs to a write |
| rspId | output | 8 | Identifier of the answered transaction |
| rspData | output | 32 | Response data |

## Verification
Several properties are checked on every cycle. The checker keeps its own credit count, so no word may go out without a credit and returned credits may never exceed the buffer depth. Opening and closing tags must pair up, the tag bits that are always zero must stay zero, and every header must carry this terminal's number and a legal opcode. The ready signal must stay low while a packet is on the wire, and a response beat must follow exactly one cycle after a closing word. Some behaviours can only be shown by the bench's scenarios against its queue-based model. These are the exact word contents and order, a stall that holds back part of a packet until credits return, a request held through a busy period, one-word and multi-word response packets, and identifiers that arrive out of order.

// File: rtl/pktwrap_pkg.sv
package pktwrap_pkg;
  localparam int DATA_W  = 32;
  localparam int TAG_W   = 4;
  localparam int FLIT_W  = DATA_W + TAG_W;
  localparam int BOP_BIT = 32;
  localparam int EOP_BIT = 33;
  localparam int ID_W    = 8;
  localparam logic [7:0] OP_READ  = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;

  typedef enum logic [1:0] {W_IDLE, W_HDR, W_ADDR, W_DATA} word_e;

  typedef struct packed {
    logic  load;  // capture the request fields
    word_e sel;   // which word sits on the link
    logic  last;  // current word closes the packet
  } strobe_t;
endpackage

// File: rtl/pktwrap_ctrl.sv
module pktwrap_ctrl
  import pktwrap_pkg::*;
#(
  parameter int CREDITS = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  input  logic    linkCredit,
  output logic    reqReady,
  output logic    linkValid,
  output strobe_t stb
);
  localparam int CW = $clog2(CREDITS + 1);

  word_e         state;
  logic          isWr;
  logic [CW-1:0] credit;
  logic          fire;

  assign fire      = (state != W_IDLE) && (credit != '0);
  assign reqReady  = (state == W_IDLE);
  assign linkValid = fire;

  always_comb begin
    stb.load = (state == W_IDLE) && reqValid;
    stb.sel  = state;
    stb.last = ((state == W_ADDR) && !isWr) || (state == W_DATA);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= W_IDLE;
      isWr   <= 1'b0;
      credit <= CW'(CREDITS);
    end else begin
      credit <= credit - CW'(fire) + CW'(linkCredit);
      case (state)
        W_IDLE: if (reqValid) begin
          state <= W_HDR;
          isWr  <= reqWrite;
        end
        W_HDR:  if (fire) state <= W_ADDR;
        W_ADDR: if (fire) state <= isWr ? W_DATA : W_IDLE;
        W_DATA: if (fire) state <= W_IDLE;
        default: state <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pktwrap_dpath.sv
module pktwrap_dpath
  import pktwrap_pkg::*;
#(
  parameter logic [7:0] SRC_TERM = 8'h05
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [ID_W-1:0]   reqId,
  output logic [FLIT_W-1:0] linkFlit,
  input  logic              rspLinkValid,
  input  logic [FLIT_W-1:0] rspLinkFlit,
  output logic              rspValid,
  output logic              rspWrite,
  output logic [ID_W-1:0]   rspId,
  output logic [DATA_W-1:0] rspData
);
  logic [DATA_W-1:0] addrQ, dataQ;
  logic [ID_W-1:0]   idQ;
  logic              wrQ;
  logic [DATA_W-1:0] word;
  logic [ID_W-1:0]   hdrId;
  logic [7:0]        hdrOp;
  logic              inBop, inEop;
  logic [7:0]        curOp;

  always_ff @(posedge clk) begin
    if (stb.load) begin
      addrQ <= reqAddr;
      dataQ <= reqWdata;
      idQ   <= reqId;
      wrQ   <= reqWrite;
    end
  end

  always_comb begin
    case (stb.sel)
      W_HDR:   word = {addrQ[31:24], SRC_TERM, idQ, wrQ ? OP_WRITE : OP_READ};
      W_ADDR:  word = addrQ;
      W_DATA:  word = dataQ;
      default: word = '0;
    endcase
  end

  assign linkFlit = {2'b00, stb.last, stb.sel == W_HDR, word};

  // response side: header remembered, beat issued on the closing word
  assign inBop = rspLinkFlit[BOP_BIT];
  assign inEop = rspLinkFlit[EOP_BIT];
  assign curOp = inBop ? rspLinkFlit[7:0] : hdrOp;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspWrite <= 1'b0;
      rspId    <= '0;
      rspData  <= '0;
      hdrId    <= '0;
      hdrOp    <= '0;
    end else begin
      rspValid <= rspLinkValid && inEop;
      if (rspLinkValid && inBop) begin
        hdrId <= rspLinkFlit[15:8];
        hdrOp <= rspLinkFlit[7:0];
      end
      if (rspLinkValid && inEop) begin
        rspId    <= inBop ? rspLinkFlit[15:8] : hdrId;
        rspWrite <= (curOp == OP_WRITE);
        rspData  <= inBop ? '0 : rspLinkFlit[31:0];
      end
    end
  end
endmodule

// File: rtl/req_pkt_wrapper.sv
module req_pkt_wrapper
  import pktwrap_pkg::*;
#(
  parameter logic [7:0] SRC_TERM = 8'h05,
  parameter int         CREDITS  = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic        reqWrite,
  input  logic [31:0] reqAddr,
  input  logic [31:0] reqWdata,
  input  logic [7:0]  reqId,
  output logic        linkValid,
  output logic [35:0] linkFlit,
  input  logic        linkCredit,
  input  logic        rspLinkValid,
  input  logic [35:0] rspLinkFlit,
  output logic        rspValid,
  output logic        rspWrite,
  output logic [7:0]  rspId,
  output logic [31:0] rspData
);
  strobe_t stb;

  pktwrap_ctrl #(.CREDITS(CREDITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .linkCredit(linkCredit), .reqReady(reqReady), .linkValid(linkValid),
    .stb(stb)
  );

  pktwrap_dpath #(.SRC_TERM(SRC_TERM)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqId(reqId),
    .linkFlit(linkFlit), .rspLinkValid(rspLinkValid),
    .rspLinkFlit(rspLinkFlit), .rspValid(rspValid), .rspWrite(rspWrite),
    .rspId(rspId), .rspData(rspData)
  );
endmodule

// File: rtl/pktwrap_chk.sv
module pktwrap_chk #(
  parameter logic [7:0] SRC_TERM = 8'h05,
  parameter int         CREDITS  = 4
) (
  input logic        clk,
  input logic        rstN,
  input logic        reqReady,
  input logic        linkValid,
  input logic [35:0] linkFlit,
  input logic        linkCredit,
  input logic        rspLinkValid,
  input logic [35:0] rspLinkFlit,
  input logic        rspValid
);
  int   ckCredit;
  logic ckInPkt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ckCredit <= CREDITS;
      ckInPkt  <= 1'b0;
    end else begin
      ckCredit <= ckCredit - (linkValid ? 1 : 0) + (linkCredit ? 1 : 0);
      if (linkValid) ckInPkt <= !linkFlit[33];
    end
  end

  assert_credit_R5: assert property (@(posedge clk) disable iff (!rstN)
    linkValid |-> ckCredit > 0);
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    ckCredit <= CREDITS);
  assert_open_R4: assert property (@(posedge clk) disable iff (!rstN)
    (linkValid && linkFlit[32]) |-> !ckInPkt);
  assert_inner_R4: assert property (@(posedge clk) disable iff (!rstN)
    (linkValid && !linkFlit[32]) |-> ckInPkt);
  assert_tags_R4: assert property (@(posedge clk) disable iff (!rstN)
    linkValid |-> linkFlit[35:34] == 2'b00);
  assert_header_R2: assert property (@(posedge clk) disable iff (!rstN)
    (linkValid && linkFlit[32]) |->
      (linkFlit[23:16] == SRC_TERM && (linkFlit[7:0] == 8'h01 || linkFlit[7:0] == 8'h02)));
  assert_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    linkValid |-> !reqReady);
  assert_beat_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rspLinkValid && rspLinkFlit[33]) |=> rspValid);
  assert_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !$past(rspLinkValid && rspLinkFlit[33])) |-> 1'b0);
endmodule

bind req_pkt_wrapper pktwrap_chk #(.SRC_TERM(SRC_TERM), .CREDITS(CREDITS)) u_chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .linkValid(linkValid),
  .linkFlit(linkFlit), .linkCredit(linkCredit), .rspLinkValid(rspLinkValid),
  .rspLinkFlit(rspLinkFlit), .rspValid(rspValid)
);

// File: tb/sim_req_pkt_wrapper.sv
module sim_req_pkt_wrapper;
  localparam logic [7:0] SRC = 8'h05;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, linkCredit = 1'b0;
  logic [31:0] reqAddr = '0, reqWdata = '0;
  logic [7:0]  reqId = '0;
  logic        rspLinkValid = 1'b0;
  logic [35:0] rspLinkFlit = '0;
  logic        reqReady, linkValid, rspValid, rspWrite;
  logic [35:0] linkFlit;
  logic [7:0]  rspId;
  logic [31:0] rspData;

  always #2 clk = ~clk;

  req_pkt_wrapper #(.SRC_TERM(SRC), .CREDITS(4)) u0 (.*);

  int    errors = 0, checks = 0;
  string phase = "R1", rspTag = "R8";
  bit    modelOn = 1'b0, autoRet = 1'b0, sentFlag = 1'b0;
  int    manualCredits = 0;
  bit [35:0] flitQ[$];
  int    credit = 4;
  bit    busy, expV;
  bit    pendV = 1'b0, pendWr = 1'b0;
  bit [7:0]  pendId = '0, hOp = '0, hId = '0;
  bit [31:0] pendData = '0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s [%s] actual=%h expected=%h", req, phase, act, exp);
    end
  endtask

  // reference model, compared every clock at the falling edge
  always @(negedge clk) if (modelOn) begin
    busy = flitQ.size() > 0;
    expV = busy && credit > 0;
    chk("R7", 64'(reqReady), 64'(!busy));
    chk("R5", 64'(linkValid), 64'(expV));
    if (expV && linkValid) begin
      chk("R4", 64'(linkFlit[35:32]), 64'(flitQ[0][35:32]));
      chk(flitQ[0][32] ? "R2" : "R3", 64'(linkFlit[31:0]), 64'(flitQ[0][31:0]));
    end
    chk(rspTag, 64'(rspValid), 64'(pendV));
    if (pendV && rspValid) begin
      chk(rspTag, 64'(rspId), 64'(pendId));
      chk(rspTag, 64'(rspData), 64'(pendData));
      chk(rspTag, 64'(rspWrite), 64'(pendWr));
    end
    sentFlag = expV;
    if (expV) begin
      void'(flitQ.pop_front());
      credit--;
    end
    if (linkCredit) credit++;
    if (reqValid && !busy) begin
      flitQ.push_back({2'b00, 1'b0, 1'b1, reqAddr[31:24], SRC, reqId,
                       reqWrite ? 8'h02 : 8'h01});
      flitQ.push_back({2'b00, !reqWrite, 1'b0, reqAddr});
      if (reqWrite) flitQ.push_back({2'b00, 1'b1, 1'b0, reqWdata});
    end
    pendV = 1'b0;
    if (rspLinkValid) begin
      if (rspLinkFlit[32]) begin
        hId = rspLinkFlit[15:8];
        hOp = rspLinkFlit[7:0];
      end
      if (rspLinkFlit[33]) begin
        pendV    = 1'b1;
        pendId   = hId;
        pendWr   = (hOp == 8'h02);
        pendData = rspLinkFlit[32] ? 32'h0 : rspLinkFlit[31:0];
      end
    end
  end

  // link partner returning credits
  always @(posedge clk) begin
    #1;
    if (autoRet) linkCredit = sentFlag;
    else if (manualCredits > 0) begin
      linkCredit = 1'b1;
      manualCredits--;
    end else linkCredit = 1'b0;
  end

  task automatic sendReq(bit wr, logic [31:0] a, logic [31:0] d, logic [7:0] id);
    bit ok;
    @(posedge clk); #1;
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d; reqId = id;
    do begin
      @(negedge clk); ok = reqReady;
      @(posedge clk);
    end while (!ok);
    #1 reqValid = 1'b0;
  endtask

  task automatic rspWord(bit bop, bit eop, logic [31:0] w);
    @(posedge clk); #1;
    rspLinkValid = 1'b1;
    rspLinkFlit = {2'b00, eop, bop, w};
  endtask

  task automatic rspIdle();
    @(posedge clk); #1 rspLinkValid = 1'b0;
  endtask

  task automatic waitCycles(int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", 64'(reqReady), 64'd1);
    chk("R1", 64'(linkValid), 64'd0);
    chk("R1", 64'(rspValid), 64'd0);
    @(posedge clk); #1 rstN = 1'b1; modelOn = 1'b1;
    @(negedge clk);
    chk("R1", 64'(reqReady), 64'd1);

    // R2/R3: write to top destination, consumes three of four credits
    phase = "R2";
    sendReq(1'b1, 32'hFF12_3456, 32'hDEAD_BEEF, 8'h11);
    waitCycles(4);
    // R5: read with one credit left stalls after the header
    phase = "R5";
    sendReq(1'b0, 32'h0000_0010, 32'h0, 8'h22);
    waitCycles(6);
    // R6: credits come back one per pulse and the read finishes
    phase = "R6";
    manualCredits = 3;
    waitCycles(8);
    manualCredits = 1;
    waitCycles(4);
    // R7/R6: back-to-back requests with credits echoed every cycle
    phase = "R7";
    autoRet = 1'b1;
    for (int i = 0; i < 4; i++)
      sendReq(i[0], {8'(i * 37 + 3), 24'h00A5C3 + 24'(i)}, 32'h1000_0000 + 32'(i), 8'(8'h40 + i));
    waitCycles(8);
    // R3: address and data patterns
    phase = "R3";
    sendReq(1'b1, 32'h0000_0000, 32'hFFFF_FFFF, 8'hFF);
    sendReq(1'b0, 32'h8001_7FFE, 32'h0, 8'h00);
    waitCycles(6);

    // R8: read response header + data
    rspTag = "R8"; phase = "R8";
    rspWord(1'b1, 1'b0, {8'd5, 8'd9, 8'h33, 8'h01});
    rspWord(1'b0, 1'b1, 32'hCAFE_F00D);
    rspIdle(); waitCycles(2);
    // R9: one-word write acknowledge
    rspTag = "R9"; phase = "R9";
    rspWord(1'b1, 1'b1, {8'd5, 8'd2, 8'h44, 8'h02});
    rspIdle(); waitCycles(2);
    // R10: out-of-order ids, back to back, then a long payload
    rspTag = "R10"; phase = "R10";
    rspWord(1'b1, 1'b1, {8'd5, 8'd1, 8'h07, 8'h02});
    rspWord(1'b1, 1'b0, {8'd5, 8'd1, 8'h03, 8'h01});
    rspWord(1'b0, 1'b1, 32'h0000_0303);
    rspWord(1'b1, 1'b0, {8'd5, 8'd1, 8'h09, 8'h01});
    rspWord(1'b0, 1'b0, 32'h1111_1111);
    rspWord(1'b0, 1'b0, 32'h2222_2222);
    rspWord(1'b0, 1'b1, 32'h3333_3333);
    rspIdle(); waitCycles(4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule